// File: doc/BRIEF.md
# Invalidation Acknowledgement Tracker

This block keeps the acknowledgement bookkeeping for one outstanding transaction of a shared second-level cache directory that records its sharers as a bit-vector. When a request arrives, it works out two things at once from the line's current sharer vector, the requester's index and the request kind. The first is the signed acknowledgement count that the response to the requester must carry. The second is the set of nodes that must receive an invalidation. Both are purely combinational.

When the directory opens a transaction, a pending counter takes the number of sharers. Each incoming acknowledgement carries a positive count that is subtracted from that value. If the subtraction would reach zero, the arrival is flagged as the last one in the same cycle and the transaction closes. An acknowledgement that arrives with nothing open, or one that would take the counter below zero, raises an error and leaves the state alone. Every channel here is a plain per-cycle strobe that is accepted at once, so there is no back-pressure.

Request kinds are encoded on `req_kind` as follows: 2'b00 read, 2'b01 write, 2'b10 upgrade, 2'b11 replacement.

Top module: `ack_tracker`

## Requirements
- R1: For a read (kind 2'b00), `resp_ack` is 0 and `inv_mask` is all zeros.
- R2: For a write (kind 2'b01), `resp_ack` equals minus the number of set bits in `sharers`, plus one when `sharers[req_id]` is set. `inv_mask` equals `sharers` with bit `req_id` cleared.
- R3: For an upgrade (kind 2'b10), `resp_ack` equals one minus the number of set bits in `sharers`. `inv_mask` equals `sharers` with bit `req_id` cleared.
- R4: For a replacement (kind 2'b11), `inv_mask` equals `sharers` in full and `resp_ack` is 0.
- R5: In the cycle after `alloc` is high, `pending` equals the number of set bits that `sharers` held in the alloc cycle. `busy` is then high exactly when that count is non-zero.
- R6: The last-ack case is a cycle with `ack_valid` high, `alloc` low, `busy` high and `ack_cnt` equal to `pending`. In that cycle `ack_last` is high, and in the next cycle `busy` is low and `pending` is 0.
- R7: The partial-ack case is a cycle with `ack_valid` high, `alloc` low, `busy` high and `ack_cnt` below `pending`. In that cycle `ack_last` is low, and in the next cycle `pending` has fallen by `ack_cnt` while `busy` stays high.
- R8: `ack_valid` high with `alloc` low and `busy` low raises `err` in that cycle, leaves `ack_last` low, and changes neither `pending` nor `busy`.
- R9: `ack_valid` high with `alloc` low, `busy` high and `ack_cnt` above `pending` raises `err`, leaves `ack_last` low, and changes neither `pending` nor `busy`.
- R10: When `alloc` and `ack_valid` are high in the same cycle, the acknowledgement is discarded. Both `ack_last` and `err` stay low, and only the load of R5 takes effect.
- R11: After reset, `busy` is low and `pending` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sharers | input | NODES | Current sharer vector of the line |
| req_id | input | IDW | Index of the requesting node |
| req_kind | input | 2 | Request kind (read, write, upgrade, replacement) |
| alloc | input | 1 | Open a transaction and load the pending counter |
| ack_valid | input | 1 | Incoming acknowledgement strobe |
| ack_cnt | input | CW | Positive count carried by the incoming acknowledgement |
| resp_ack | output | CW+1 | Signed acknowledgement count for the response |
| inv_mask | output | NODES | Nodes to invalidate |
| pending | output | CW | Acknowledgements still outstanding |
| busy | output | 1 | A transaction is open |
| ack_last | output | 1 | This acknowledgement completes the transaction |
| err | output | 1 | Acknowledgement arrived while idle or would overrun the counter |

## Verification
The assertions assume that `req_id` is below NODES and that every input is driven to a known value once reset is released. Within that range, any pattern of sharers, kinds, allocs and acknowledgements is legal, including stray acknowledgements and overruns, which are themselves checked. The stimulus keeps `req_id` inside the node range and holds every strobe at a defined level from reset onward. It also deliberately sends the illegal acknowledgement sequences, because their handling is part of the required behaviour.

// File: rtl/ack_trk_pkg.sv
package ack_trk_pkg;
  typedef enum logic [1:0] {
    KIND_READ    = 2'b00,
    KIND_WRITE   = 2'b01,
    KIND_UPGRADE = 2'b10,
    KIND_REPLACE = 2'b11
  } req_kind_e;
endpackage

// File: rtl/ack_popcnt.sv
module ack_popcnt #(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  // ripple sum of single bits; each stage widened to the final width
  logic [CW-1:0] part [W+1];
  assign part[0] = '0;
  for (genvar g = 0; g < W; g++) begin : g_sum
    assign part[g+1] = part[g] + CW'(vec[g]);
  end
  assign cnt = part[W];
endmodule

// File: rtl/ack_resp_calc.sv
module ack_resp_calc
  import ack_trk_pkg::*;
#(
  parameter int NODES = 8,
  parameter int IDW   = (NODES > 1) ? $clog2(NODES) : 1,
  parameter int CW    = $clog2(NODES + 1),
  parameter int AW    = CW + 1
) (
  input  logic [NODES-1:0]     sharers,
  input  logic [IDW-1:0]       req_id,
  input  req_kind_e            kind,
  input  logic [CW-1:0]        pop,
  output logic signed [AW-1:0] resp_ack,
  output logic [NODES-1:0]     inv_mask
);
  logic [NODES-1:0] req_onehot;
  logic             req_is_sharer;

  assign req_onehot    = NODES'(1) << req_id;
  assign req_is_sharer = |(sharers & req_onehot);

  always_comb begin
    resp_ack = '0;
    inv_mask = '0;
    unique case (kind)
      KIND_READ: begin
        resp_ack = '0;
        inv_mask = '0;
      end
      KIND_WRITE: begin
        resp_ack = AW'(0) - AW'(pop) + AW'(req_is_sharer);
        inv_mask = sharers & ~req_onehot;
      end
      KIND_UPGRADE: begin
        resp_ack = AW'(1) - AW'(pop);
        inv_mask = sharers & ~req_onehot;
      end
      KIND_REPLACE: begin
        resp_ack = '0;
        inv_mask = sharers;
      end
      default: begin
        resp_ack = '0;
        inv_mask = '0;
      end
    endcase
  end

  // R2 R3 R4: invalidations only ever go to current sharers
  always_comb begin
    if (!$isunknown({sharers, req_id, kind})) begin
      mask_subset_chk: assert ((inv_mask & ~sharers) == '0)
        else $error("invalidation mask reaches a non-sharer");
    end
  end
endmodule

// File: rtl/ack_pend_ctr.sv
module ack_pend_ctr #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  input  logic [CW-1:0] load_val,
  input  logic          ack_valid,
  input  logic [CW-1:0] ack_cnt,
  output logic [CW-1:0] pending,
  output logic          busy,
  output logic          last,
  output logic          err
);
  logic take, exceed;

  assign take   = ack_valid && !alloc;
  assign exceed = ack_cnt > pending;
  assign last   = take && busy && (ack_cnt == pending);
  assign err    = take && (!busy || exceed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
      busy    <= 1'b0;
    end else if (alloc) begin
      pending <= load_val;
      busy    <= (load_val != '0);
    end else if (last) begin
      pending <= '0;
      busy    <= 1'b0;
    end else if (take && busy && !exceed) begin
      pending <= pending - ack_cnt;
    end
  end

  // R5
  alloc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> (pending == $past(load_val)))
    else $error("pending not loaded on alloc");

  // R6
  last_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (!busy && pending == '0))
    else $error("transaction still open after last ack");

  // R7
  pend_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc |=> (pending <= $past(pending)))
    else $error("pending grew without alloc");

  // R8 R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> ($stable(pending) && $stable(busy)))
    else $error("state changed on a rejected ack");

  // R6 R9
  last_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(last && err))
    else $error("ack both last and erroneous");

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (pending == '0))
    else $error("idle with acks outstanding");
endmodule

// File: rtl/ack_tracker.sv
module ack_tracker
  import ack_trk_pkg::*;
#(
  parameter int NODES = 8,
  localparam int IDW  = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int CW   = $clog2(NODES + 1),
  localparam int AW   = CW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NODES-1:0]     sharers,
  input  logic [IDW-1:0]       req_id,
  input  logic [1:0]           req_kind,
  input  logic                 alloc,
  input  logic                 ack_valid,
  input  logic [CW-1:0]        ack_cnt,
  output logic signed [AW-1:0] resp_ack,
  output logic [NODES-1:0]     inv_mask,
  output logic [CW-1:0]        pending,
  output logic                 busy,
  output logic                 ack_last,
  output logic                 err
);
  logic [CW-1:0] pop;

  ack_popcnt #(.W(NODES), .CW(CW)) u_pop (
    .vec (sharers),
    .cnt (pop)
  );

  ack_resp_calc #(.NODES(NODES), .IDW(IDW), .CW(CW), .AW(AW)) u_resp (
    .sharers  (sharers),
    .req_id   (req_id),
    .kind     (req_kind_e'(req_kind)),
    .pop      (pop),
    .resp_ack (resp_ack),
    .inv_mask (inv_mask)
  );

  ack_pend_ctr #(.CW(CW)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc     (alloc),
    .load_val  (pop),
    .ack_valid (ack_valid),
    .ack_cnt   (ack_cnt),
    .pending   (pending),
    .busy      (busy),
    .last      (ack_last),
    .err       (err)
  );
endmodule

// File: tb/ack_tracker_bench.sv
module ack_tracker_bench;
  localparam int NODES = 8;
  localparam int IDW   = 3;
  localparam int CW    = 4;
  localparam int AW    = 5;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NODES-1:0]     sharers = '0;
  logic [IDW-1:0]       req_id = '0;
  logic [1:0]           req_kind = 2'b00;
  logic                 alloc = 1'b0;
  logic                 ack_valid = 1'b0;
  logic [CW-1:0]        ack_cnt = '0;
  logic signed [AW-1:0] resp_ack;
  logic [NODES-1:0]     inv_mask;
  logic [CW-1:0]        pending;
  logic                 busy, ack_last, err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ack_tracker #(.NODES(NODES)) u_ack_tracker (
    .clk(clk), .rst_n(rst_n), .sharers(sharers), .req_id(req_id),
    .req_kind(req_kind), .alloc(alloc), .ack_valid(ack_valid),
    .ack_cnt(ack_cnt), .resp_ack(resp_ack), .inv_mask(inv_mask),
    .pending(pending), .busy(busy), .ack_last(ack_last), .err(err)
  );

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ones(logic [NODES-1:0] v);
    int n = 0;
    for (int i = 0; i < NODES; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // open a transaction and check the load
  task automatic open_txn(logic [NODES-1:0] s);
    sharers = s; alloc = 1'b1; ack_valid = 1'b0;
    step();
    alloc = 1'b0;
    chk("R5", "pending", int'(pending), ones(s));
    chk("R5", "busy", int'(busy), int'(ones(s) != 0));
  endtask

  // send one ack, check strobes, then resulting state
  task automatic send_ack(int c, int exp_last, int exp_err, int exp_pend, int exp_busy, string req);
    ack_valid = 1'b1; ack_cnt = CW'(c);
    #1;
    chk(req, "ack_last", int'(ack_last), exp_last);
    chk(req, "err", int'(err), exp_err);
    step();
    ack_valid = 1'b0;
    chk(req, "pending", int'(pending), exp_pend);
    chk(req, "busy", int'(busy), exp_busy);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #20;
    rst_n = 1'b1;
    step();
    // R11
    chk("R11", "busy", int'(busy), 0);
    chk("R11", "pending", int'(pending), 0);

    // exhaustive combinational sweep: R1 R2 R3 R4
    for (int s = 0; s < (1 << NODES); s++) begin
      for (int id = 0; id < NODES; id++) begin
        for (int k = 0; k < 4; k++) begin
          logic [NODES-1:0] sv, ex_mask;
          int ex_ack, p;
          string rq;
          sv = NODES'(s);
          p = ones(sv);
          sharers = sv; req_id = IDW'(id); req_kind = 2'(k);
          #1;
          case (k)
            0: begin ex_ack = 0; ex_mask = '0; rq = "R1"; end
            1: begin ex_ack = -p + int'(sv[id]); ex_mask = sv & ~(NODES'(1) << id); rq = "R2"; end
            2: begin ex_ack = 1 - p; ex_mask = sv & ~(NODES'(1) << id); rq = "R3"; end
            default: begin ex_ack = 0; ex_mask = sv; rq = "R4"; end
          endcase
          chk(rq, "resp_ack", int'(resp_ack), ex_ack);
          chk(rq, "inv_mask", int'(inv_mask), int'(ex_mask));
        end
      end
    end
    req_kind = 2'b00; req_id = '0;
    step();

    // one-by-one acks for several sharer populations: R5 R6 R7 R8
    begin
      logic [NODES-1:0] pats [6] = '{8'h00, 8'h01, 8'h03, 8'h0F, 8'hFF, 8'hA5};
      foreach (pats[i]) begin
        int p;
        p = ones(pats[i]);
        open_txn(pats[i]);
        for (int r = p; r >= 1; r--) begin
          if (r == 1) send_ack(1, 1, 0, 0, 0, "R6");
          else        send_ack(1, 0, 0, r - 1, 1, "R7");
        end
        // stray ack once closed
        send_ack(1, 0, 1, 0, 0, "R8");
      end
    end

    // split acks and overrun: R7 R9 R6
    open_txn(8'hFF);
    send_ack(3, 0, 0, 5, 1, "R7");
    send_ack(6, 0, 1, 5, 1, "R9");
    send_ack(0, 0, 0, 5, 1, "R7");
    send_ack(5, 1, 0, 0, 0, "R6");

    // alloc and ack in the same cycle: R10
    sharers = 8'h0F; alloc = 1'b1; ack_valid = 1'b1; ack_cnt = CW'(4);
    #1;
    chk("R10", "ack_last", int'(ack_last), 0);
    chk("R10", "err", int'(err), 0);
    step();
    alloc = 1'b0; ack_valid = 1'b0;
    chk("R10", "pending", int'(pending), 4);
    chk("R10", "busy", int'(busy), 1);
    send_ack(4, 1, 0, 0, 0, "R6");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule